// File: doc/BRIEF.md
# Dual-Channel Performance Event Counter

This block gives a processor two independent event counters on a small register port. Each channel has a 16-bit control word. The control word picks one of 33 event codes from a sparse 6-bit code space, and it holds a start bit, an enable bit, a clear request and a clock-divide flag. Each channel accumulates a 48-bit count. Software reads the count as a high word, which carries the upper 16 bits in its low half, and a 32-bit low word.

The processor drives event strobes on a 64-bit input vector that is indexed by event code. There is one exception: code 0x23 measures elapsed time from the block's own clock, so its strobe pin is ignored. Software arms a channel in two writes. The first write sets the clear request. The second write sets the event code together with start and enable. To stop a channel, software clears enable and leaves the code alone. To disable it, software clears both enable and the code. The count words can also be written, so software can preload a value.

Top module: `pmc_dual`

## Requirements
- R1: After reset, every control word and every count reads zero.
- R2: A control write stores code bits [5:0], the divide flag at bit 8, start at bit 14 and enable at bit 15. Readback returns those bits, and every other bit reads 0, including the clear bit 13.
- R3: A control write with bit 13 set zeroes that channel's count at the next clock edge. This takes priority over counting in the same cycle.
- R4: A count advances by exactly one on a clock edge only when enable and start are both set and the selected event is active. Start without enable, or enable without start, leaves the count unchanged.
- R5: The valid codes are 0x01-0x0B, 0x0D-0x1A, 0x21-0x25 and 0x27-0x29. Code n selects evt_in[n]. Any other code (0x00, 0x0C, 0x1B-0x20, 0x26, 0x2A-0x3F) never counts.
- R6: Code 0x23 counts every clock cycle whatever evt_in holds. With the divide flag set, it counts once per 4 cycles, from a free-running divider.
- R7: The high word returns count[47:32] in bits [15:0] and zeros in bits [31:16]. The low word returns count[31:0].
- R8: The address map is: control of channel n at 0x00+4n; high word at 0x20+8n; low word at 0x24+8n. Any other address reads 0.
- R9: Writing the high word loads count[47:32] from wdata[15:0], and writing the low word loads count[31:0]. The count carries from the low word into the high word, and it wraps from all ones to zero.
- R10: The two channels count independently, each from its own selected event.
- R11: A control write that clears only enable freezes the count and keeps the code, the divide flag and start on readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| evt_in | input | 64 | Event strobes, indexed by event code |

## Verification
The hardest behaviour to reach from the ports is the 48-bit carry and the wrap from all ones to zero. At one event per cycle, that point lies out of reach. The bench therefore preloads both count words through the register port, then sends a single event pulse and reads back both words. The divide-by-4 elapsed count depends on the free-running divider's phase, so it is measured over a window of exactly 40 counting edges. Any phase then gives 10.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int CODE_W   = 6;
    localparam int CTL_W    = 16;
    localparam int NUM_EVT  = 1 << CODE_W;
    localparam int B_CLKDIV = 8;
    localparam int B_CLR    = 13;
    localparam int B_START  = 14;
    localparam int B_EN     = 15;
    localparam logic [CODE_W-1:0] EV_ELAPSED = 6'h23;

    typedef struct packed {
        logic              en;
        logic              st;
        logic              ck;
        logic [CODE_W-1:0] code;
    } ctl_t;

    function automatic logic code_valid(input logic [CODE_W-1:0] c);
        return (c >= 6'h01 && c <= 6'h0B) || (c >= 6'h0D && c <= 6'h1A) ||
               (c >= 6'h21 && c <= 6'h25) || (c >= 6'h27 && c <= 6'h29);
    endfunction

    function automatic logic [CTL_W-1:0] ctl_view(input ctl_t c);
        return {c.en, c.st, 5'b0, c.ck, 2'b0, c.code};
    endfunction
endpackage

// File: rtl/pmc_prescaler.sv
module pmc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);

    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pmc_event_sel.sv
module pmc_event_sel
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_t               ctl,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               tick,
    output logic               hit
);
    logic raw;

    always_comb begin
        if (ctl.code == EV_ELAPSED) raw = ctl.ck ? tick : 1'b1;
        else                        raw = evt_in[ctl.code];
        hit = code_valid(ctl.code) & raw;
    end

    // R5: codes outside the valid set must stay silent
    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.code == 6'h00 || ctl.code == 6'h0C || ctl.code == 6'h26 ||
         ctl.code > 6'h29) |-> !hit);
endmodule

// File: rtl/pmc_channel.sv
module pmc_channel
    import pmc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [31:0]      wdata,
    input  logic             hit,
    output ctl_t             ctl_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int HI_W = CNT_W - 32;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  clr_req, armed;

    always_comb begin
        st_d    = st_q;
        clr_req = ctl_we & wdata[B_CLR];
        armed   = st_q.ctl.en & st_q.ctl.st;
        if (ctl_we) begin
            st_d.ctl.en   = wdata[B_EN];
            st_d.ctl.st   = wdata[B_START];
            st_d.ctl.ck   = wdata[B_CLKDIV];
            st_d.ctl.code = wdata[CODE_W-1:0];
        end
        if (clr_req)           st_d.cnt = '0;
        else if (hi_we)        st_d.cnt[CNT_W-1:32] = wdata[HI_W-1:0];
        else if (lo_we)        st_d.cnt[31:0] = wdata;
        else if (armed && hit) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_q = st_q.ctl;
    assign cnt_q = st_q.cnt;

    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wdata[B_CLR]) |=> (cnt_q == '0));

    a_r4_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we && wdata[B_CLR]) && !hi_we && !lo_we |=>
        (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.en && ctl_q.st) && !(ctl_we && wdata[B_CLR]) && !hi_we && !lo_we
        |=> $stable(cnt_q));

    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.en && ctl_q.st && hit && (cnt_q == '1) && !ctl_we && !hi_we && !lo_we
        |=> (cnt_q == '0));
endmodule

// File: rtl/pmc_dual.sv
module pmc_dual
    import pmc_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int CNT_W    = 48,
    parameter int ADDR_W   = 8,
    parameter int CTL_BASE = 'h00,
    parameter int CNT_BASE = 'h20,
    parameter int DIV      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [63:0]       evt_in
);
    localparam int HI_W = CNT_W - 32;

    ctl_t             ctl_q [NUM_CH];
    logic [CNT_W-1:0] cnt_q [NUM_CH];
    logic [NUM_CH-1:0] ctl_hit, hi_hit, lo_hit, ev_hit;
    logic             tick;

    pmc_prescaler #(.DIV(DIV)) u_presc (.clk(clk), .rst_n(rst_n), .tick(tick));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ctl_hit[g] = (reg_addr == ADDR_W'(CTL_BASE + 4 * g));
        assign hi_hit[g]  = (reg_addr == ADDR_W'(CNT_BASE + 8 * g));
        assign lo_hit[g]  = (reg_addr == ADDR_W'(CNT_BASE + 8 * g + 4));

        pmc_event_sel u_sel (
            .clk(clk), .rst_n(rst_n), .ctl(ctl_q[g]), .evt_in(evt_in),
            .tick(tick), .hit(ev_hit[g]));

        pmc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctl_we(reg_wr & ctl_hit[g]), .hi_we(reg_wr & hi_hit[g]),
            .lo_we(reg_wr & lo_hit[g]), .wdata(reg_wdata),
            .hit(ev_hit[g]), .ctl_q(ctl_q[g]), .cnt_q(cnt_q[g]));
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ctl_hit[i]) reg_rdata = {16'b0, ctl_view(ctl_q[i])};
            if (hi_hit[i])  reg_rdata = {{(32 - HI_W){1'b0}}, cnt_q[i][CNT_W-1:32]};
            if (lo_hit[i])  reg_rdata = cnt_q[i][31:0];
        end
    end

    a_r7_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|hi_hit) |-> (reg_rdata[31:16] == 16'h0));

    a_r2_clear_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_hit) |-> (reg_rdata[B_CLR] == 1'b0));
endmodule

// File: tb/pmc_dual_test.sv
module pmc_dual_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [63:0] evt_in = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    localparam logic [7:0] C0 = 8'h00, C1 = 8'h04;
    localparam logic [7:0] H0 = 8'h20, L0 = 8'h24, H1 = 8'h28, L1 = 8'h2C;

    pmc_dual uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
                  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in));

    always #10 clk = ~clk;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%02h got=%08h exp=%08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic pulse(input int bitn, input int n);
        evt_in[bitn] = 1;
        repeat (n) @(negedge clk);
        evt_in[bitn] = 0;
    endtask

    task automatic t_reset;
        rd_chk("R1", C0, 0); rd_chk("R1", C1, 0);
        rd_chk("R1", H0, 0); rd_chk("R1", L0, 0);
        rd_chk("R1", H1, 0); rd_chk("R1", L1, 0);
        rd_chk("R8", 8'h08, 0);
    endtask

    task automatic t_readback;
        wr(C0, 32'h0000_FFFF);
        rd_chk("R2", C0, 32'h0000_C13F);
        wr(C0, 32'h0000_0000);
        rd_chk("R2", C0, 0);
    endtask

    task automatic t_count_and_indep;
        wr(C0, 32'h2000); wr(C0, 32'hC001);
        wr(C1, 32'h2000); wr(C1, 32'hC002);
        pulse(1, 5);
        pulse(2, 3);
        rd_chk("R4", L0, 5);
        rd_chk("R10", L1, 3);
        rd_chk("R7", H0, 0);
    endtask

    task automatic t_arm_bits;
        wr(C0, 32'h2000); wr(C0, 32'h4001);
        pulse(1, 4);
        rd_chk("R4 start only", L0, 0);
        wr(C0, 32'h8001);
        pulse(1, 4);
        rd_chk("R4 enable only", L0, 0);
    endtask

    task automatic t_reserved;
        logic [5:0] bad [4] = '{6'h00, 6'h0C, 6'h26, 6'h3F};
        for (int i = 0; i < 4; i++) begin
            wr(C0, 32'h2000); wr(C0, 32'hC000 | bad[i]);
            evt_in = '1;
            repeat (6) @(negedge clk);
            evt_in = '0;
            rd_chk("R5 reserved", L0, 0);
        end
        wr(C0, 32'h2000); wr(C0, 32'hC029);
        pulse(41, 7);
        rd_chk("R5 code 0x29", L0, 7);
    endtask

    task automatic t_clear_priority;
        wr(C0, 32'h2000); wr(C0, 32'hC001);
        evt_in[1] = 1;
        repeat (4) @(negedge clk);
        wr(C0, 32'hE001);
        evt_in[1] = 0;
        rd_chk("R3", L0, 0);
    endtask

    task automatic t_elapsed;
        wr(C0, 32'h2000); wr(C0, 32'hC023);
        repeat (9) @(negedge clk);
        wr(C0, 32'h0023);
        rd_chk("R6 elapsed", L0, 10);
        rd_chk("R11 code kept", C0, 32'h0023);
        evt_in = '1;
        repeat (5) @(negedge clk);
        evt_in = '0;
        rd_chk("R11 frozen", L0, 10);
        wr(C0, 32'h2000); wr(C0, 32'hC123);
        repeat (39) @(negedge clk);
        wr(C0, 32'h0123);
        rd_chk("R6 divided", L0, 10);
        wr(C0, 32'h0000);
        rd_chk("R11 disable clears code", C0, 0);
    endtask

    task automatic t_wrap;
        wr(C0, 32'h2000); wr(C0, 32'hC001);
        wr(H0, 32'hFFFF_FFFF); wr(L0, 32'hFFFF_FFFF);
        rd_chk("R7 upper zero", H0, 32'h0000_FFFF);
        rd_chk("R9 load low", L0, 32'hFFFF_FFFF);
        pulse(1, 1);
        rd_chk("R9 wrap high", H0, 0);
        rd_chk("R9 wrap low", L0, 0);
        wr(H0, 32'h0); wr(L0, 32'hFFFF_FFFF);
        pulse(1, 1);
        rd_chk("R9 carry high", H0, 1);
        rd_chk("R9 carry low", L0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_count_and_indep();
        t_arm_bits();
        t_reserved();
        t_clear_priority();
        t_elapsed();
        t_wrap();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule